// File: doc/BRIEF.md
# Ethernet transmit error monitor

This block follows one Ethernet frame transmission at a time and sorts the faults that happen during it. It counts bit-time ticks from frame start to tell in-slot collisions from late ones. It counts retransmission attempts, tracks loss of carrier and watches a short window after the frame ends for the transceiver's heartbeat collision. From these it drives per-frame status bits, a request to end the frame with a corrupted CRC, an abort strobe, mask-gated interrupt pulses and a strobe that moves the transmit DMA on to the next descriptor.

Each fault has its own handling. Three of them abort the frame and close its remaining buffers: a FIFO underrun (after a 32-bit bad-CRC tail), an exhausted retry budget and a late collision. Carrier loss only marks status, and the frame finishes normally. The heartbeat check runs only after a frame that ends normally. The serializer, the CRC generator, the backoff timer and the descriptor DMA are outside the block.

Top module: `eth_tx_err_mon`

## Requirements
- R1: After reset, and again in the cycle after an accepted `frame_start_i` (accepted only when no frame is active), `stat_o` is zero. `abort_o`, `bad_crc_o`, `irq_o` and `next_desc_o` are low after reset.
- R2: The `stat_o` encoding is: bit 0 underrun, bit 1 carrier lost, bit 2 retry limit, bit 3 late collision, bit 4 heartbeat error. The `irq_mask_i` and `irq_o` encoding is: bit 0 underrun, bit 1 retry limit, bit 2 late collision, bit 3 heartbeat.
- R3: A transmit FIFO underrun during a frame sets stat bit 0 in the following cycle and raises `bad_crc_o`. `bad_crc_o` stays high for exactly 32 bit ticks. In the cycle after the 32nd tick, `abort_o` and `next_desc_o` pulse for one cycle and `bad_crc_o` falls.
- R4: If carrier sense is low in any cycle of a frame and the frame had no collision, stat bit 1 is set when the frame ends. The frame closes normally with no abort and no interrupt.
- R5: A collision in a frame suppresses the carrier-lost status, even when carrier was lost.
- R6: A collision (rising edge of `coll_i`) seen before 512 bit ticks have elapsed since the frame start, or since the previous collision, is a retry. It sets no status and restarts the tick count.
- R7: The 16th retry collision in a frame sets stat bit 2 and pulses `abort_o` and `next_desc_o`.
- R8: A collision seen once 512 or more bit ticks have elapsed sets stat bit 3 and pulses `abort_o` and `next_desc_o` in the next cycle. A collision after exactly 511 ticks counts as a retry.
- R9: With `hb_chk_en_i` high, if `coll_i` is high in any of the 20 clock cycles after the frame-end cycle, `next_desc_o` pulses in the cycle after that collision and no status is set. If `coll_i` stays low for all 20 cycles, stat bit 4 and `next_desc_o` are set after the 20th cycle. With the check disabled, `next_desc_o` pulses in the cycle after frame end.
- R10: Each interrupt is a one-cycle pulse, raised in the same cycle as its status bit, and only when its mask bit is 1.
- R11: Once an abort cause is taken, further underrun, collision and frame-end inputs have no effect on status, abort or advance until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One pulse per transmitted bit time |
| frame_start_i | input | 1 | Start of a frame (preamble begins) |
| frame_end_i | input | 1 | Last bit of the frame sent |
| fifo_unrun_i | input | 1 | Transmit FIFO ran dry |
| coll_i | input | 1 | Collision indication from the transceiver |
| crs_i | input | 1 | Carrier sense |
| hb_chk_en_i | input | 1 | Enable the post-frame heartbeat check |
| irq_mask_i | input | 4 | Interrupt enables, encoded as in R2 |
| stat_o | output | 5 | Per-frame status, encoded as in R2 |
| abort_o | output | 1 | One-cycle frame abort strobe |
| bad_crc_o | output | 1 | Send bits that force a CRC error |
| irq_o | output | 4 | Interrupt pulses |
| next_desc_o | output | 1 | Close the frame and advance to the next descriptor |

## Verification
The bench aims at the slot boundary, with collisions after 511 and after 512 ticks. A monitor that compared with the wrong bound would abort a legal retry or miss a late collision. It counts retries to exactly 15 and then 16, which exposes an off-by-one in the attempt limit. It places the heartbeat collision in the 20th and the 21st cycle after frame end, so a window one cycle short or long reports a heartbeat error on a good transceiver or accepts a late one. It also sends collisions and underruns into a frame that is already aborting or jamming; a monitor that let a later cause win would overwrite status or pulse abort twice.

// File: rtl/eth_txmon_pkg.sv
package eth_txmon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEND   = 2'd1,
    ST_JAM    = 2'd2,
    ST_HBWAIT = 2'd3
  } txmon_state_e;

  localparam int N_STAT = 5;
  localparam int SB_UN  = 0;
  localparam int SB_CSL = 1;
  localparam int SB_RL  = 2;
  localparam int SB_LC  = 3;
  localparam int SB_HB  = 4;

  localparam int N_IRQ  = 4;
  localparam int IB_UN  = 0;
  localparam int IB_RL  = 1;
  localparam int IB_LC  = 2;
  localparam int IB_HB  = 3;
endpackage

// File: rtl/txmon_span_ctr.sv
// Counts LEN steps; last_o flags the step that completes the span.
module txmon_span_ctr #(
  parameter int LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic last_o
);
  localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt_q;

  assign last_o = step_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (last_o)  cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  // R3
  span_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/txmon_slot_ctr.sv
// Saturating bit-time counter; late_o once the slot time has elapsed.
module txmon_slot_ctr #(
  parameter int SLOT_BITS = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic late_o
);
  localparam int W = $clog2(SLOT_BITS + 1);
  localparam logic [W-1:0] SLOT = W'(SLOT_BITS);

  logic [W-1:0] cnt_q;

  assign late_o = (cnt_q == SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (tick_i && !late_o)  cnt_q <= cnt_q + 1'b1;
  end

  // R8
  slot_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_o && !clr_i |=> late_o);
endmodule

// File: rtl/txmon_attempt_ctr.sv
// Per-frame retry counter; limit_o on the collision that uses the last attempt.
module txmon_attempt_ctr #(
  parameter int MAX_ATTEMPTS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic limit_o
);
  localparam int W = (MAX_ATTEMPTS > 1) ? $clog2(MAX_ATTEMPTS) : 1;
  localparam logic [W-1:0] LAST = W'(MAX_ATTEMPTS - 1);

  logic [W-1:0] cnt_q;

  assign limit_o = inc_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !limit_o) cnt_q <= cnt_q + 1'b1;
  end

  // R7
  att_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !clr_i |=> $stable(cnt_q));
endmodule

// File: rtl/eth_tx_err_mon.sv
module eth_tx_err_mon
  import eth_txmon_pkg::*;
#(
  parameter int SLOT_BITS    = 512,
  parameter int MAX_ATTEMPTS = 16,
  parameter int JAM_BITS     = 32,
  parameter int HB_WINDOW    = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  input  logic             fifo_unrun_i,
  input  logic             coll_i,
  input  logic             crs_i,
  input  logic             hb_chk_en_i,
  input  logic [N_IRQ-1:0] irq_mask_i,
  output logic [N_STAT-1:0] stat_o,
  output logic             abort_o,
  output logic             bad_crc_o,
  output logic [N_IRQ-1:0] irq_o,
  output logic             next_desc_o
);
  txmon_state_e state_q, state_d;

  logic [N_STAT-1:0] stat_q, stat_d;
  logic [N_IRQ-1:0]  irq_q, irq_d;
  logic abort_q, abort_d, next_q, next_d;
  logic coll_q, csl_q, csl_d, colseen_q, colseen_d;

  logic in_send, coll_rise, start;
  logic ev_un, ev_late, ev_coll_in, ev_rl, ev_retry, ev_end;
  logic slot_late, att_limit, jam_done, hb_ok, hb_miss, hb_enter;
  logic csl_now;

  assign in_send    = (state_q == ST_SEND);
  assign coll_rise  = coll_i && !coll_q;
  assign start      = (state_q == ST_IDLE) && frame_start_i;

  // Abort cause priority inside one cycle: underrun, then collision, then end.
  assign ev_un      = in_send && fifo_unrun_i;
  assign ev_late    = in_send && !fifo_unrun_i && coll_rise && slot_late;
  assign ev_coll_in = in_send && !fifo_unrun_i && coll_rise && !slot_late;
  assign ev_rl      = ev_coll_in && att_limit;
  assign ev_retry   = ev_coll_in && !att_limit;
  assign ev_end     = in_send && frame_end_i && !fifo_unrun_i && !coll_rise;
  assign hb_enter   = ev_end && hb_chk_en_i;
  assign hb_ok      = (state_q == ST_HBWAIT) && coll_i;
  assign csl_now    = csl_q || !crs_i;

  txmon_slot_ctr #(.SLOT_BITS(SLOT_BITS)) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start || ev_retry),
    .tick_i (in_send && bit_tick_i),
    .late_o (slot_late)
  );

  txmon_attempt_ctr #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_att (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start),
    .inc_i   (ev_coll_in),
    .limit_o (att_limit)
  );

  txmon_span_ctr #(.LEN(JAM_BITS)) u_jam (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ev_un),
    .step_i ((state_q == ST_JAM) && bit_tick_i),
    .last_o (jam_done)
  );

  txmon_span_ctr #(.LEN(HB_WINDOW)) u_hb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (hb_enter),
    .step_i ((state_q == ST_HBWAIT) && !coll_i),
    .last_o (hb_miss)
  );

  always_comb begin
    state_d   = state_q;
    stat_d    = stat_q;
    irq_d     = '0;
    abort_d   = 1'b0;
    next_d    = 1'b0;
    csl_d     = csl_q;
    colseen_d = colseen_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d   = ST_SEND;
          stat_d    = '0;
          csl_d     = 1'b0;
          colseen_d = 1'b0;
        end
      end
      ST_SEND: begin
        if (!crs_i) csl_d = 1'b1;
        if (ev_un) begin
          state_d        = ST_JAM;
          stat_d[SB_UN]  = 1'b1;
          irq_d[IB_UN]   = irq_mask_i[IB_UN];
        end else if (ev_late) begin
          state_d        = ST_IDLE;
          stat_d[SB_LC]  = 1'b1;
          irq_d[IB_LC]   = irq_mask_i[IB_LC];
          abort_d        = 1'b1;
          next_d         = 1'b1;
        end else if (ev_rl) begin
          state_d        = ST_IDLE;
          stat_d[SB_RL]  = 1'b1;
          irq_d[IB_RL]   = irq_mask_i[IB_RL];
          abort_d        = 1'b1;
          next_d         = 1'b1;
        end else if (ev_retry) begin
          colseen_d      = 1'b1;
        end else if (ev_end) begin
          stat_d[SB_CSL] = csl_now && !colseen_q;
          if (hb_chk_en_i) begin
            state_d = ST_HBWAIT;
          end else begin
            state_d = ST_IDLE;
            next_d  = 1'b1;
          end
        end
      end
      ST_JAM: begin
        if (jam_done) begin
          state_d = ST_IDLE;
          abort_d = 1'b1;
          next_d  = 1'b1;
        end
      end
      ST_HBWAIT: begin
        if (hb_ok) begin
          state_d = ST_IDLE;
          next_d  = 1'b1;
        end else if (hb_miss) begin
          state_d       = ST_IDLE;
          stat_d[SB_HB] = 1'b1;
          irq_d[IB_HB]  = irq_mask_i[IB_HB];
          next_d        = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      stat_q    <= '0;
      irq_q     <= '0;
      abort_q   <= 1'b0;
      next_q    <= 1'b0;
      coll_q    <= 1'b0;
      csl_q     <= 1'b0;
      colseen_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      stat_q    <= stat_d;
      irq_q     <= irq_d;
      abort_q   <= abort_d;
      next_q    <= next_d;
      coll_q    <= coll_i;
      csl_q     <= csl_d;
      colseen_q <= colseen_d;
    end
  end

  assign stat_o      = stat_q;
  assign irq_o       = irq_q;
  assign abort_o     = abort_q;
  assign next_desc_o = next_q;
  assign bad_crc_o   = (state_q == ST_JAM);

  // R10
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |=> (irq_o == '0));

  // R10
  irq_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));

  // R11
  abort_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  // R11
  one_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({stat_o[SB_UN], stat_o[SB_RL], stat_o[SB_LC]}) <= 1);

  // R3
  un_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o && stat_o[SB_UN] |-> $past(bad_crc_o) && !bad_crc_o);

  // R8
  lc_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[SB_LC]) |-> abort_o && next_desc_o);

  // R4
  csl_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[SB_CSL]) |-> !abort_o && (irq_o == '0));

  // R3
  jam_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_crc_o |-> stat_o[SB_UN] && !abort_o);
endmodule

// File: tb/sim_eth_tx_err_mon.sv
`timescale 1ns/1ps
module sim_eth_tx_err_mon;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_tick_i = 1'b0;
  logic       frame_start_i = 1'b0;
  logic       frame_end_i = 1'b0;
  logic       fifo_unrun_i = 1'b0;
  logic       coll_i = 1'b0;
  logic       crs_i = 1'b1;
  logic       hb_chk_en_i = 1'b0;
  logic [3:0] irq_mask_i = 4'h0;
  logic [4:0] stat_o;
  logic       abort_o, bad_crc_o, next_desc_o;
  logic [3:0] irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  eth_tx_err_mon u0 (
    .clk_i, .rst_ni, .bit_tick_i, .frame_start_i, .frame_end_i,
    .fifo_unrun_i, .coll_i, .crs_i, .hb_chk_en_i, .irq_mask_i,
    .stat_o, .abort_o, .bad_crc_o, .irq_o, .next_desc_o
  );

  // Expected encodings (R2)
  function automatic logic [4:0] sbit(input int idx);
    return 5'(1) << idx;
  endfunction
  function automatic logic [3:0] exp_irq(input logic [3:0] m, input int idx);
    return m[idx] ? (4'(1) << idx) : 4'h0;
  endfunction

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    bit_tick_i = 1'b1;
    repeat (n) cyc();
    bit_tick_i = 1'b0;
  endtask

  task automatic start_frame();
    frame_start_i = 1'b1; cyc(); frame_start_i = 1'b0;
    chk("R1", "stat after start", stat_o, 0);
  endtask

  task automatic pulse_coll();
    coll_i = 1'b1; cyc(); coll_i = 1'b0;
  endtask

  task automatic t_normal(input int n);
    start_frame();
    ticks(n);
    frame_end_i = 1'b1; cyc(); frame_end_i = 1'b0;
    chk("R9", "next after end (no hb)", next_desc_o, 1);
    chk("R1", "stat clean frame", stat_o, 0);
    chk("R11", "abort clean frame", abort_o, 0);
    cyc();
    chk("R9", "next single pulse", next_desc_o, 0);
  endtask

  task automatic t_underrun(input int pre);
    start_frame();
    ticks(pre);
    fifo_unrun_i = 1'b1; cyc(); fifo_unrun_i = 1'b0;
    chk("R3", "UN status", stat_o, sbit(0));
    chk("R10", "UN irq", irq_o, exp_irq(irq_mask_i, 0));
    chk("R3", "bad crc raised", bad_crc_o, 1);
    cyc();
    chk("R10", "irq one cycle", irq_o, 0);
    pulse_coll();
    frame_end_i = 1'b1; cyc(); frame_end_i = 1'b0;
    chk("R11", "stat unchanged in jam", stat_o, sbit(0));
    chk("R11", "no early advance", next_desc_o, 0);
    ticks(JAM - 1);
    chk("R3", "bad crc after 31 ticks", bad_crc_o, 1);
    chk("R3", "no abort after 31 ticks", abort_o, 0);
    ticks(1);
    chk("R3", "abort after 32 ticks", abort_o, 1);
    chk("R3", "next after 32 ticks", next_desc_o, 1);
    chk("R3", "bad crc dropped", bad_crc_o, 0);
    cyc();
    chk("R3", "abort single pulse", abort_o, 0);
  endtask

  localparam int JAM = 32;

  task automatic t_csl(input bit with_coll, input int a);
    start_frame();
    ticks(a);
    crs_i = 1'b0; cyc(); crs_i = 1'b1;
    if (with_coll) begin
      ticks(3);
      pulse_coll();
      chk("R6", "retry sets no status", stat_o, 0);
      chk("R6", "retry no abort", abort_o, 0);
    end
    ticks(5);
    frame_end_i = 1'b1; cyc(); frame_end_i = 1'b0;
    if (with_coll) chk("R5", "CSL suppressed", stat_o, 0);
    else           chk("R4", "CSL set", stat_o, sbit(1));
    chk("R4", "CSL no irq", irq_o, 0);
    chk("R4", "CSL no abort", abort_o, 0);
    chk("R4", "CSL frame closes", next_desc_o, 1);
    cyc();
  endtask

  task automatic t_late(input int extra);
    start_frame();
    ticks(512 + extra);
    pulse_coll();
    chk("R8", "LC status", stat_o, sbit(3));
    chk("R8", "LC abort", abort_o, 1);
    chk("R8", "LC next", next_desc_o, 1);
    chk("R10", "LC irq", irq_o, exp_irq(irq_mask_i, 2));
    cyc();
    chk("R8", "LC abort pulse", abort_o, 0);
    fifo_unrun_i = 1'b1; cyc(); fifo_unrun_i = 1'b0;
    pulse_coll();
    frame_end_i = 1'b1; cyc(); frame_end_i = 1'b0;
    chk("R11", "stat after ignored events", stat_o, sbit(3));
    chk("R11", "no jam after abort", bad_crc_o, 0);
    chk("R11", "no advance after abort", next_desc_o, 0);
  endtask

  task automatic t_slot_edge();
    start_frame();
    ticks(511);
    pulse_coll();
    chk("R8", "511 ticks is retry: stat", stat_o, 0);
    chk("R8", "511 ticks is retry: abort", abort_o, 0);
    ticks(511);
    pulse_coll();
    chk("R6", "count restarts after retry", stat_o, 0);
    ticks(512);
    pulse_coll();
    chk("R8", "late after restart", stat_o, sbit(3));
    cyc();
  endtask

  task automatic t_rl();
    start_frame();
    for (int i = 1; i <= 15; i++) begin
      ticks(1 + int'($urandom % 40));
      pulse_coll();
    end
    chk("R7", "15 retries no status", stat_o, 0);
    chk("R7", "15 retries no abort", abort_o, 0);
    ticks(2);
    pulse_coll();
    chk("R7", "RL status", stat_o, sbit(2));
    chk("R7", "RL abort", abort_o, 1);
    chk("R7", "RL next", next_desc_o, 1);
    chk("R10", "RL irq", irq_o, exp_irq(irq_mask_i, 1));
    cyc();
  endtask

  task automatic t_hb(input int kc);
    bit fin;
    hb_chk_en_i = 1'b1;
    start_frame();
    ticks(10);
    frame_end_i = 1'b1; cyc(); frame_end_i = 1'b0;
    chk("R9", "no advance at end with hb", next_desc_o, 0);
    fin = 1'b0;
    for (int k = 1; k <= 21 && !fin; k++) begin
      coll_i = (k == kc);
      cyc();
      coll_i = 1'b0;
      if (k == kc && kc <= 20) begin
        chk("R9", "hb ok advance", next_desc_o, 1);
        chk("R9", "hb ok no status", stat_o, 0);
        fin = 1'b1;
      end else if (k == 20) begin
        chk("R9", "hb error status", stat_o, sbit(4));
        chk("R9", "hb error advance", next_desc_o, 1);
        chk("R10", "hb irq", irq_o, exp_irq(irq_mask_i, 3));
        fin = 1'b1;
      end else begin
        chk("R9", "hb waiting", next_desc_o, 0);
      end
    end
    hb_chk_en_i = 1'b0;
    cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    cyc(); cyc();
    chk("R1", "reset stat", stat_o, 0);
    chk("R1", "reset abort", abort_o, 0);
    chk("R1", "reset bad crc", bad_crc_o, 0);
    chk("R1", "reset irq", irq_o, 0);
    chk("R1", "reset next", next_desc_o, 0);
    rst_ni = 1'b1;
    cyc();

    irq_mask_i = 4'hf;
    t_normal(20);
    t_underrun(7);
    t_csl(1'b0, 30);
    t_csl(1'b1, 30);
    t_slot_edge();
    t_late(0);
    t_rl();
    t_hb(20);
    t_hb(21);
    t_hb(1);
    irq_mask_i = 4'h0;
    t_underrun(0);
    t_late(3);

    for (int it = 0; it < 40; it++) begin
      irq_mask_i = 4'($urandom);
      case ($urandom % 7)
        0: t_normal(1 + int'($urandom % 100));
        1: t_underrun(int'($urandom % 50));
        2: t_csl(1'($urandom), 1 + int'($urandom % 200));
        3: t_late(int'($urandom % 30));
        4: t_rl();
        5: t_hb(1 + int'($urandom % 24));
        default: t_slot_edge();
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule